// File: doc/BRIEF.md
# Clock-Generator Configuration Slave on a Two-Wire Bus

This block is the two-wire (I2C) slave for a programmable clock generator. It runs on a fast system clock that oversamples SCL and SDA. It detects START, repeated START and STOP conditions, and it matches its own 7-bit device address. It then lets a bus master write or read one configuration byte per transaction. The second byte of every write sets a register pointer. A read sends that pointer in a short write, then a repeated START, the read address byte, one returned byte and a NACK from the master.

Three registers are held in a working copy that drives the generator directly:
- a mode byte: dither rate, phase mode, dither amount and prescaler;
- a frequency code in the low nibble of a second register;
- an address/defer register: a commit-deferral flag and the three low bits of the device address.

A single-cycle request tells an external nonvolatile store when the working copy must be saved. A busy input from that store makes the slave ignore its own address.

The commit policy follows the deferral flag. With the flag clear, every accepted register write is saved. With the flag set, only a dedicated command byte causes a save. The address/defer register is always saved on write. A newly written device address is used for matching only after the STOP that closes the transaction that wrote it.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: After reset the mode byte is CDh, the frequency code is 0, the deferral flag is 0, the device select bits are 0, SDA is released and no commit request is raised.
- R2: The slave acknowledges an address byte only when its upper seven bits equal binary 1011 followed by the live select bits (bit 0 is R/W, 1 means read). On a mismatch it acknowledges nothing more until the next START.
- R3: In a write, the second byte is the register pointer and the third byte is data. Pointer 02h stores all 8 bits as the mode byte. Pointer 08h stores bits 3:0 as the frequency code. Pointer 0Dh stores bit 3 as the deferral flag and bits 2:0 as the select bits. Other pointers store nothing.
- R4: A read returns the register at the current pointer, MSB first. Bits 7:4 of registers 08h and 0Dh read as 1. Pointer 02h returns the mode byte.
- R5: With the deferral flag at 0, each accepted data write to 02h or 08h raises exactly one commit pulse of one clock cycle.
- R6: With the deferral flag at 1, writes to 02h and 08h update the working copy but raise no commit. Receiving 3Fh as the pointer byte raises one commit.
- R7: A data write to 0Dh raises one commit whatever the deferral flag is.
- R8: While the busy input is high, the slave does not acknowledge its own address.
- R9: The live select bits used for matching take the register value only at a STOP. Until then the previous address still matches, including after a repeated START.
- R10: A START or STOP at any point resets the byte state machine and releases SDA.
- R11: The slave changes SDA only while SCL is low and never holds SCL low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| nv_busy | input | 1 | Nonvolatile store is saving |
| nv_commit_req | output | 1 | One-cycle request to save the working copy |
| cfg_mode | output | 8 | Mode byte (dither rate, phase, dither amount, prescaler) |
| cfg_freq | output | 4 | Frequency code |
| cfg_defer | output | 1 | Commit deferral flag |
| cfg_dev_sel | output | 3 | Device select bits as last written |

## Verification
The checker watches every cycle for four things:
- a commit request always lasts one cycle;
- no address acknowledge is given while the store is busy;
- the live select bits change only right after a STOP, and SDA is released after each STOP;
- the slave only starts pulling SDA while the synchronized SCL is low.

The register map, the ones padding on readback, the commit counts under each deferral setting, address mismatch, and the old address still matching after a repeated START are shown only by the bench's bus transactions. So is the recovery from a STOP that cuts a byte short.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    localparam int BYTE_W = 8;
    localparam int DEV_W  = 7;

    localparam logic [7:0] PTR_MODE   = 8'h02;
    localparam logic [7:0] PTR_FREQ   = 8'h08;
    localparam logic [7:0] PTR_ADDR   = 8'h0D;
    localparam logic [7:0] CMD_COMMIT = 8'h3F;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_TXACK
    } bus_state_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_PTR,
        PH_DATA,
        PH_EXTRA
    } byte_phase_e;

    typedef struct packed {
        logic [1:0] dither_rate;
        logic [1:0] phase_mode;
        logic [1:0] dither_amt;
        logic [1:0] prescale;
    } mode_reg_t;

    function automatic byte_phase_e next_phase(input byte_phase_e cur);
        case (cur)
            PH_DEV:  return PH_PTR;
            PH_PTR:  return PH_DATA;
            default: return PH_EXTRA;
        endcase
    endfunction

endpackage

// File: rtl/clkcfg_line_sampler.sv
module clkcfg_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_pipe;
    logic [TOP:0] sda_pipe;
    logic         scl_q;
    logic         sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[TOP-1:0], scl_in};
            sda_pipe <= {sda_pipe[TOP-1:0], sda_in};
            scl_q    <= scl_pipe[TOP];
            sda_q    <= sda_pipe[TOP];
        end
    end

    always_comb begin
        scl_s    = scl_pipe[TOP];
        sda_s    = sda_pipe[TOP];
        scl_rise = scl_s & ~scl_q;
        scl_fall = ~scl_s & scl_q;
        start_ev = scl_s & scl_q & sda_q & ~sda_s;
        stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/clkcfg_byte_engine.sv
module clkcfg_byte_engine
    import clkcfg_pkg::*;
#(
    parameter logic [3:0] PREFIX = 4'b1011,
    parameter int          SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda_s,
    input  logic             start_ev,
    input  logic             stop_ev,
    input  logic [SEL_W-1:0] dev_sel,
    input  logic             nv_busy,
    input  logic [7:0]       rd_data,
    output logic             sda_oe,
    output logic             dev_ack_ev,
    output logic             ptr_ev,
    output logic             wr_ev,
    output logic [7:0]       rx_byte
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

    bus_state_e  state;
    byte_phase_e phase;
    logic [CNT_W-1:0] cnt;
    logic [7:0] rx_sh;
    logic [7:0] tx_sh;
    logic       ack_next;
    logic       is_read;
    logic       mst_ack;
    logic [7:0] byte_now;
    logic       dev_hit;

    always_comb begin
        byte_now = {rx_sh[6:0], sda_s};
        dev_hit  = (byte_now[7:1] == {PREFIX, dev_sel}) && !nv_busy;
    end

    assign rx_byte = rx_sh;

    always_ff @(posedge clk) begin
        dev_ack_ev <= 1'b0;
        ptr_ev     <= 1'b0;
        wr_ev      <= 1'b0;
        if (rst) begin
            state    <= ST_IDLE;
            phase    <= PH_DEV;
            cnt      <= '0;
            rx_sh    <= '0;
            tx_sh    <= '1;
            sda_oe   <= 1'b0;
            ack_next <= 1'b0;
            is_read  <= 1'b0;
            mst_ack  <= 1'b0;
        end else if (start_ev) begin
            state  <= ST_RX;
            phase  <= PH_DEV;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (stop_ev) begin
            state  <= ST_IDLE;
            phase  <= PH_DEV;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise && cnt != FULL) begin
                        rx_sh <= byte_now;
                        cnt   <= cnt + 1'b1;
                        if (cnt == LAST_BIT) begin
                            case (phase)
                                PH_DEV: begin
                                    ack_next   <= dev_hit;
                                    dev_ack_ev <= dev_hit;
                                    is_read    <= byte_now[0];
                                end
                                PH_PTR: begin
                                    ack_next <= 1'b1;
                                    ptr_ev   <= 1'b1;
                                end
                                PH_DATA: begin
                                    ack_next <= 1'b1;
                                    wr_ev    <= 1'b1;
                                end
                                default: ack_next <= 1'b0;
                            endcase
                        end
                    end else if (scl_fall && cnt == FULL) begin
                        cnt <= '0;
                        if (ack_next) begin
                            sda_oe <= 1'b1;
                            state  <= ST_ACK;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (phase == PH_DEV && is_read) begin
                            sda_oe <= ~rd_data[7];
                            tx_sh  <= {rd_data[6:0], 1'b1};
                            state  <= ST_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            phase  <= next_phase(phase);
                            state  <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        cnt <= cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (cnt == FULL) begin
                            sda_oe <= 1'b0;
                            state  <= ST_TXACK;
                        end else begin
                            sda_oe <= ~tx_sh[7];
                            tx_sh  <= {tx_sh[6:0], 1'b1};
                        end
                    end
                end
                ST_TXACK: begin
                    if (scl_rise) begin
                        mst_ack <= ~sda_s;
                    end else if (scl_fall) begin
                        cnt <= '0;
                        if (mst_ack) begin
                            sda_oe <= ~rd_data[7];
                            tx_sh  <= {rd_data[6:0], 1'b1};
                            state  <= ST_TX;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/clkcfg_regfile.sv
module clkcfg_regfile
    import clkcfg_pkg::*;
#(
    parameter logic [7:0] MODE_RST = 8'hCD,
    parameter int         FREQ_W   = 4,
    parameter int         SEL_W    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ptr_ev,
    input  logic              wr_ev,
    input  logic [7:0]        rx_byte,
    input  logic              stop_ev,
    output mode_reg_t         mode,
    output logic [FREQ_W-1:0] freq,
    output logic              defer,
    output logic [SEL_W-1:0]  sel,
    output logic [SEL_W-1:0]  sel_live,
    output logic [7:0]        rd_data,
    output logic              wr_addr_hit,
    output logic              wr_other_hit,
    output logic              cmd_ev
);
    localparam int FREQ_PAD = BYTE_W - FREQ_W;
    localparam int ADDR_PAD = BYTE_W - SEL_W - 1;

    logic [7:0] ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= mode_reg_t'(MODE_RST);
            freq     <= '0;
            defer    <= 1'b0;
            sel      <= '0;
            sel_live <= '0;
            ptr      <= '0;
        end else begin
            if (ptr_ev) begin
                ptr <= rx_byte;
            end
            if (wr_ev) begin
                case (ptr)
                    PTR_MODE: mode <= mode_reg_t'(rx_byte);
                    PTR_FREQ: freq <= rx_byte[FREQ_W-1:0];
                    PTR_ADDR: begin
                        defer <= rx_byte[SEL_W];
                        sel   <= rx_byte[SEL_W-1:0];
                    end
                    default: ;
                endcase
            end
            if (stop_ev) begin
                sel_live <= sel;
            end
        end
    end

    always_comb begin
        case (ptr)
            PTR_MODE: rd_data = mode;
            PTR_FREQ: rd_data = {{FREQ_PAD{1'b1}}, freq};
            PTR_ADDR: rd_data = {{ADDR_PAD{1'b1}}, defer, sel};
            default:  rd_data = 8'hFF;
        endcase
        wr_addr_hit  = wr_ev && (ptr == PTR_ADDR);
        wr_other_hit = wr_ev && (ptr == PTR_MODE || ptr == PTR_FREQ);
        cmd_ev       = ptr_ev && (rx_byte == CMD_COMMIT);
    end

endmodule

// File: rtl/clkcfg_commit_ctl.sv
module clkcfg_commit_ctl (
    input  logic clk,
    input  logic rst,
    input  logic wr_addr_hit,
    input  logic wr_other_hit,
    input  logic cmd_ev,
    input  logic defer,
    output logic commit_req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            commit_req <= 1'b0;
        end else begin
            commit_req <= wr_addr_hit | cmd_ev | (wr_other_hit & ~defer);
        end
    end

endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave
    import clkcfg_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] PREFIX      = 4'b1011,
    parameter logic [7:0] MODE_RST    = 8'hCD,
    parameter int         FREQ_W      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic              nv_busy,
    output logic              nv_commit_req,
    output logic [7:0]        cfg_mode,
    output logic [FREQ_W-1:0] cfg_freq,
    output logic              cfg_defer,
    output logic [2:0]        cfg_dev_sel
);
    localparam int SEL_W = DEV_W - $bits(PREFIX);

    logic scl_sync, sda_sync, scl_rise, scl_fall, start_sync, stop_sync;
    logic dev_ack_ev, ptr_ev, wr_ev, wr_addr_hit, wr_other_hit, cmd_ev;
    logic [7:0] rx_byte, rd_data;
    logic [SEL_W-1:0] sel_live;
    mode_reg_t mode_q;

    clkcfg_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) sampler_i (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_sync), .sda_s(sda_sync), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_ev(start_sync), .stop_ev(stop_sync)
    );

    clkcfg_byte_engine #(.PREFIX(PREFIX), .SEL_W(SEL_W)) engine_i (
        .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_s(sda_sync), .start_ev(start_sync), .stop_ev(stop_sync),
        .dev_sel(sel_live), .nv_busy(nv_busy), .rd_data(rd_data),
        .sda_oe(sda_oe), .dev_ack_ev(dev_ack_ev), .ptr_ev(ptr_ev),
        .wr_ev(wr_ev), .rx_byte(rx_byte)
    );

    clkcfg_regfile #(.MODE_RST(MODE_RST), .FREQ_W(FREQ_W), .SEL_W(SEL_W)) regs_i (
        .clk(clk), .rst(rst), .ptr_ev(ptr_ev), .wr_ev(wr_ev), .rx_byte(rx_byte),
        .stop_ev(stop_sync), .mode(mode_q), .freq(cfg_freq), .defer(cfg_defer),
        .sel(cfg_dev_sel), .sel_live(sel_live), .rd_data(rd_data),
        .wr_addr_hit(wr_addr_hit), .wr_other_hit(wr_other_hit), .cmd_ev(cmd_ev)
    );

    clkcfg_commit_ctl commit_i (
        .clk(clk), .rst(rst), .wr_addr_hit(wr_addr_hit),
        .wr_other_hit(wr_other_hit), .cmd_ev(cmd_ev), .defer(cfg_defer),
        .commit_req(nv_commit_req)
    );

    assign cfg_mode = mode_q;

endmodule

// File: rtl/clkcfg_i2c_slave_chk.sv
module clkcfg_i2c_slave_chk (
    input logic       clk,
    input logic       rst,
    input logic       sda_oe,
    input logic       scl_sync,
    input logic       stop_sync,
    input logic       dev_ack_ev,
    input logic       nv_busy,
    input logic [2:0] sel_live,
    input logic       nv_commit_req
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!sda_oe && !nv_commit_req));

    // R5
    commit_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        nv_commit_req |=> !nv_commit_req);

    // R8
    no_ack_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        dev_ack_ev |-> !$past(nv_busy));

    // R9
    sel_change_at_stop_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel_live) |-> $past(stop_sync));

    // R10
    release_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
        stop_sync |=> !sda_oe);

    // R11
    drive_while_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_sync);

endmodule

bind clkcfg_i2c_slave clkcfg_i2c_slave_chk chk_i (
    .clk(clk), .rst(rst), .sda_oe(sda_oe), .scl_sync(scl_sync),
    .stop_sync(stop_sync), .dev_ack_ev(dev_ack_ev), .nv_busy(nv_busy),
    .sel_live(sel_live), .nv_commit_req(nv_commit_req)
);

// File: tb/clkcfg_i2c_slave_tb.sv
module clkcfg_i2c_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic nv_busy = 1'b0;
    logic sda_line;
    logic sda_oe, nv_commit_req, cfg_defer;
    logic [7:0] cfg_mode;
    logic [3:0] cfg_freq;
    logic [2:0] cfg_dev_sel;

    int checks = 0;
    int fails = 0;
    int commits = 0;
    bit done = 0;

    assign sda_line = sda_m & ~sda_oe;

    clkcfg_i2c_slave dut_i (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
        .sda_oe(sda_oe), .nv_busy(nv_busy), .nv_commit_req(nv_commit_req),
        .cfg_mode(cfg_mode), .cfg_freq(cfg_freq), .cfg_defer(cfg_defer),
        .cfg_dev_sel(cfg_dev_sel)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (!rst && nv_commit_req) commits++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wclk(Q);
        scl_m = 1'b1; wclk(Q);
        sda_m = 1'b0; wclk(Q);
        scl_m = 1'b0; wclk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wclk(Q);
        scl_m = 1'b1; wclk(Q);
        sda_m = 1'b1; wclk(2*Q);
    endtask

    task automatic send_bit(input bit b);
        sda_m = b;    wclk(Q);
        scl_m = 1'b1; wclk(2*Q);
        scl_m = 1'b0; wclk(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        bit oe_a, oe_b;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wclk(Q);
        scl_m = 1'b1; wclk(1);
        oe_a = sda_oe; wclk(Q-1);
        ack = ~sda_line; wclk(Q-1);
        oe_b = sda_oe; wclk(1);
        // R11: the slave holds SDA steady while SCL is high
        chk(oe_a == oe_b, "R11 sda steady during scl high", oe_b, oe_a);
        scl_m = 1'b0; wclk(Q);
    endtask

    task automatic read_byte(input bit nack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wclk(Q);
            scl_m = 1'b1; wclk(Q);
            d = {d[6:0], sda_line}; wclk(Q);
            scl_m = 1'b0; wclk(Q);
        end
        send_bit(nack);
        sda_m = 1'b1;
    endtask

    task automatic write_reg(input logic [7:0] dev, input logic [7:0] ptr,
                             input logic [7:0] d, output bit [2:0] acks);
        bit a;
        bus_start();
        send_byte(dev, a); acks[2] = a;
        send_byte(ptr, a); acks[1] = a;
        send_byte(d, a);   acks[0] = a;
        bus_stop();
    endtask

    task automatic read_reg(input logic [7:0] dev, input logic [7:0] ptr,
                            output logic [7:0] d, output bit ok);
        bit a1, a2, a3;
        bus_start();
        send_byte(dev, a1);
        send_byte(ptr, a2);
        bus_start();
        send_byte(dev | 8'h01, a3);
        read_byte(1'b1, d);
        bus_stop();
        ok = a1 & a2 & a3;
    endtask

    task automatic t_reset();
        chk(cfg_mode == 8'hCD, "R1 mode reset", cfg_mode, 8'hCD);
        chk(cfg_freq == 4'h0, "R1 freq reset", cfg_freq, 0);
        chk(cfg_defer == 1'b0 && cfg_dev_sel == 3'd0, "R1 addr reg reset",
            {cfg_defer, cfg_dev_sel}, 0);
        chk(sda_oe == 1'b0 && commits == 0, "R1 bus idle", sda_oe, 0);
    endtask

    task automatic t_write_auto();
        bit [2:0] acks;
        int c0 = commits;
        write_reg(8'hB0, 8'h08, 8'h0A, acks);
        chk(acks == 3'b111, "R3 write acks", acks, 7);
        chk(cfg_freq == 4'hA, "R3 freq stored", cfg_freq, 4'hA);
        chk(commits == c0 + 1, "R5 auto commit", commits - c0, 1);
        write_reg(8'hB0, 8'h02, 8'h9E, acks);
        chk(cfg_mode == 8'h9E, "R3 mode stored", cfg_mode, 8'h9E);
        chk(commits == c0 + 2, "R5 auto commit mode", commits - c0, 2);
        write_reg(8'hB0, 8'h05, 8'h33, acks);
        chk(cfg_mode == 8'h9E && cfg_freq == 4'hA && commits == c0 + 2,
            "R3 unmapped pointer ignored", commits - c0, 2);
    endtask

    task automatic t_read();
        logic [7:0] d;
        bit ok;
        read_reg(8'hB0, 8'h08, d, ok);
        chk(ok && d == 8'hFA, "R4 read freq padded", d, 8'hFA);
        read_reg(8'hB0, 8'h02, d, ok);
        chk(ok && d == 8'h9E, "R4 read mode", d, 8'h9E);
    endtask

    task automatic t_mismatch();
        bit a;
        bus_start();
        send_byte(8'hB2, a);
        chk(!a, "R2 wrong address nack", a, 0);
        send_byte(8'h08, a);
        chk(!a, "R2 ignored until start", a, 0);
        send_byte(8'h05, a);
        bus_stop();
        chk(cfg_freq == 4'hA, "R2 no write on mismatch", cfg_freq, 4'hA);
    endtask

    task automatic t_defer();
        bit [2:0] acks;
        bit a;
        logic [7:0] d;
        int c0 = commits;
        write_reg(8'hB0, 8'h0D, 8'h08, acks);
        chk(cfg_defer == 1'b1, "R3 defer flag stored", cfg_defer, 1);
        chk(commits == c0 + 1, "R7 addr reg commits", commits - c0, 1);
        write_reg(8'hB0, 8'h02, 8'h55, acks);
        chk(cfg_mode == 8'h55, "R6 working copy updated", cfg_mode, 8'h55);
        chk(commits == c0 + 1, "R6 deferred no commit", commits - c0, 1);
        bus_start();
        send_byte(8'hB0, a);
        send_byte(8'h3F, a);
        bus_stop();
        chk(a && commits == c0 + 2, "R6 command commits", commits - c0, 2);
        read_reg(8'hB0, 8'h0D, d, a);
        chk(a && d == 8'hF8, "R4 read addr reg padded", d, 8'hF8);
    endtask

    task automatic t_newaddr();
        bit a;
        bit [2:0] acks;
        bus_start();
        send_byte(8'hB0, a);
        send_byte(8'h0D, a);
        send_byte(8'h0B, a);
        bus_start();
        send_byte(8'hB0, a);
        chk(a, "R9 old address until stop", a, 1);
        bus_stop();
        chk(cfg_dev_sel == 3'd3, "R3 select stored", cfg_dev_sel, 3);
        bus_start();
        send_byte(8'hB0, a);
        bus_stop();
        chk(!a, "R9 old address dropped", a, 0);
        bus_start();
        send_byte(8'hB6, a);
        bus_stop();
        chk(a, "R9 new address acked", a, 1);
        write_reg(8'hB6, 8'h0D, 8'h00, acks);
        chk(acks == 3'b111 && cfg_dev_sel == 3'd0 && !cfg_defer,
            "R7 restore addr reg", acks, 7);
    endtask

    task automatic t_busy();
        bit a;
        nv_busy = 1'b1;
        bus_start();
        send_byte(8'hB0, a);
        bus_stop();
        chk(!a, "R8 no ack while busy", a, 0);
        nv_busy = 1'b0;
        bus_start();
        send_byte(8'hB0, a);
        bus_stop();
        chk(a, "R8 ack after busy", a, 1);
    endtask

    task automatic t_abort();
        bit [2:0] acks;
        bus_start();
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_stop();
        chk(sda_oe == 1'b0, "R10 released after stop", sda_oe, 0);
        bus_start();
        send_bit(1'b1); send_bit(1'b0);
        bus_start();
        write_reg(8'hB0, 8'h08, 8'h03, acks);
        chk(acks == 3'b111 && cfg_freq == 4'h3, "R10 recovers after restart",
            cfg_freq, 3);
    endtask

    initial begin
        wclk(CLK_PERIOD * 15000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        wclk(5);
        rst = 1'b0;
        wclk(5);
        t_reset();
        t_write_auto();
        t_read();
        t_mismatch();
        t_defer();
        t_newaddr();
        t_busy();
        t_abort();
        finish_run();
    end

endmodule